// File: doc/BRIEF.md
# Indirect PHY Register Access Port

A PHY keeps its tuning and control state in a private file of 16-bit registers that software cannot address directly. This block is a bus slave that opens that file through two 32-bit words. One word holds the PHY register address. The other word carries a 16-bit value together with three command bits: capture, write and read.

A PHY write takes two bus accesses. The first access loads the value into a staging register through the capture bit. The second access commits the staged value through the write bit. A read command sends a read strobe to the PHY, and the result can then be read back through the data word. Every output is registered, and all strobes are single-cycle pulses on the PHY side.

Top module: `iphy_access_port`

## Requirements
- R1: After a synchronous reset, both strobes are low, the staging register is zero, and both the address word (byte offset 0) and the data word (byte offset 4) read as zero.
- R2: A bus write to offset 0 stores bits 15:0 as the PHY register address and ignores bits 31:16. A read of offset 0 returns the stored address with bits 31:16 zero.
- R3: A write to offset 4 with bit 18 (capture) set loads bits 15:0 into the staging register. Capture alone raises no strobe.
- R4: A write to offset 4 with bit 17 (write) set raises `phy_wr_stb` for exactly the next cycle. During that cycle `phy_addr` carries the stored address and `phy_wdata` carries the staged value. The low 16 bits of the commit access are not used.
- R5: A write command with no capture since reset commits the reset staging value, zero.
- R6: A write to offset 4 with bit 16 (read) set, and bit 17 clear, raises `phy_rd_stb` for the next cycle. `phy_rdata` is sampled at the end of that cycle. From then on a read of offset 4 returns that value in bits 15:0, with bits 31:16 zero.
- R7: When capture and write are set in the same access, the write commits the value of that same access.
- R8: When write and read are set in the same access, the write strobe comes first. The read strobe follows one cycle later, so the read returns the value just written.
- R9: A write to offset 4 with no command bit set changes no state and raises no strobe.
- R10: `bus_rdata` is registered and valid in the cycle after `bus_rd`. Bus reads have no side effects. Offsets other than 0 and 4 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write request, one access per cycle |
| bus_rd | input | 1 | Bus read request |
| bus_addr | input | BUS_AW (4) | Byte offset within the block |
| bus_wdata | input | BUS_DW (32) | Bus write data |
| bus_rdata | output | BUS_DW (32) | Registered read data |
| phy_wr_stb | output | 1 | One-cycle PHY register write strobe |
| phy_rd_stb | output | 1 | One-cycle PHY register read strobe |
| phy_addr | output | PHY_AW (16) | PHY register address |
| phy_wdata | output | PHY_DW (16) | PHY register write value |
| phy_rdata | input | PHY_DW (16) | PHY read value, valid during `phy_rd_stb` |

## Verification
The hardest case to reach is the ordering inside a single access that combines commands. When one write sets write and read together, the read must observe the newly written value. A later access can also land while the delayed read strobe is still pending. The stimulus issues combined command words, including one with all three bits set. It also moves the address between staging and commit. A behavioural model runs alongside and predicts, on every clock, the strobes, the PHY address and data, and the read-back values.

// File: rtl/iphy_pkg.sv
package iphy_pkg;
  localparam int unsigned WIDX_ADDR = 0;
  localparam int unsigned WIDX_DATA = 1;

  typedef struct packed {
    logic set_addr;
    logic capture;
    logic commit;
    logic fetch;
  } iphy_cmd_t;
endpackage

// File: rtl/iphy_decode.sv
module iphy_decode
  import iphy_pkg::*;
#(
  parameter int BUS_AW = 4
) (
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [2:0]        cmd_bits,
  output iphy_cmd_t         cmd
);
  localparam int IW = BUS_AW - 2;

  logic [IW-1:0] widx;
  logic          data_hit;

  assign widx     = bus_addr[BUS_AW-1:2];
  assign data_hit = bus_wr && (widx == IW'(WIDX_DATA));

  always_comb begin
    cmd          = '0;
    cmd.set_addr = bus_wr && (widx == IW'(WIDX_ADDR));
    cmd.capture  = data_hit && cmd_bits[2];
    cmd.commit   = data_hit && cmd_bits[1];
    cmd.fetch    = data_hit && cmd_bits[0];
  end
endmodule

// File: rtl/iphy_stage.sv
module iphy_stage
  import iphy_pkg::*;
#(
  parameter int PHY_AW = 16,
  parameter int PHY_DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  iphy_cmd_t         cmd,
  input  logic [PHY_AW-1:0] addr_in,
  input  logic [PHY_DW-1:0] data_in,
  output logic [PHY_AW-1:0] reg_addr,
  output logic [PHY_DW-1:0] staged
);
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_addr <= '0;
      staged   <= '0;
    end else begin
      if (cmd.set_addr) reg_addr <= addr_in;
      if (cmd.capture)  staged   <= data_in;
    end
  end
endmodule

// File: rtl/iphy_seq.sv
module iphy_seq
  import iphy_pkg::*;
#(
  parameter int PHY_DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  iphy_cmd_t         cmd,
  input  logic [PHY_DW-1:0] data_in,
  input  logic [PHY_DW-1:0] staged,
  output logic              wr_stb,
  output logic              rd_stb,
  output logic [PHY_DW-1:0] wr_val
);
  logic rd_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb  <= 1'b0;
      rd_stb  <= 1'b0;
      rd_pend <= 1'b0;
      wr_val  <= '0;
    end else begin
      wr_stb  <= cmd.commit;
      rd_stb  <= (cmd.fetch && !cmd.commit) || rd_pend;
      rd_pend <= cmd.fetch && cmd.commit;
      if (cmd.commit) wr_val <= cmd.capture ? data_in : staged;
    end
  end
endmodule

// File: rtl/iphy_readback.sv
module iphy_readback
  import iphy_pkg::*;
#(
  parameter int BUS_AW = 4,
  parameter int BUS_DW = 32,
  parameter int PHY_AW = 16,
  parameter int PHY_DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              rd_stb,
  input  logic [PHY_DW-1:0] phy_rdata,
  input  logic [PHY_AW-1:0] reg_addr,
  output logic [BUS_DW-1:0] bus_rdata
);
  localparam int IW = BUS_AW - 2;

  logic [PHY_DW-1:0] result;
  logic [IW-1:0]     widx;
  logic [BUS_DW-1:0] rd_mux;

  assign widx = bus_addr[BUS_AW-1:2];

  always_comb begin
    if (widx == IW'(WIDX_ADDR))      rd_mux = BUS_DW'(reg_addr);
    else if (widx == IW'(WIDX_DATA)) rd_mux = BUS_DW'(result);
    else                             rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      bus_rdata <= '0;
    end else begin
      if (rd_stb) result    <= phy_rdata;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/iphy_access_port.sv
module iphy_access_port
  import iphy_pkg::*;
#(
  parameter int BUS_AW = 4,
  parameter int BUS_DW = 32,
  parameter int PHY_AW = 16,
  parameter int PHY_DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              phy_wr_stb,
  output logic              phy_rd_stb,
  output logic [PHY_AW-1:0] phy_addr,
  output logic [PHY_DW-1:0] phy_wdata,
  input  logic [PHY_DW-1:0] phy_rdata
);
  localparam int CMD_LSB = PHY_DW;
  localparam int CMD_MSB = PHY_DW + 2;

  iphy_cmd_t         cmd;
  logic [PHY_DW-1:0] staged;
  logic              unused_bits;

  assign unused_bits = ^{bus_addr[1:0], bus_wdata[BUS_DW-1:CMD_MSB+1]};

  iphy_decode #(.BUS_AW(BUS_AW)) u_decode (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .cmd_bits (bus_wdata[CMD_MSB:CMD_LSB]),
    .cmd      (cmd)
  );

  iphy_stage #(.PHY_AW(PHY_AW), .PHY_DW(PHY_DW)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .addr_in  (bus_wdata[PHY_AW-1:0]),
    .data_in  (bus_wdata[PHY_DW-1:0]),
    .reg_addr (phy_addr),
    .staged   (staged)
  );

  iphy_seq #(.PHY_DW(PHY_DW)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .data_in (bus_wdata[PHY_DW-1:0]),
    .staged  (staged),
    .wr_stb  (phy_wr_stb),
    .rd_stb  (phy_rd_stb),
    .wr_val  (phy_wdata)
  );

  iphy_readback #(.BUS_AW(BUS_AW), .BUS_DW(BUS_DW), .PHY_AW(PHY_AW), .PHY_DW(PHY_DW)) u_readback (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .rd_stb    (phy_rd_stb),
    .phy_rdata (phy_rdata),
    .reg_addr  (phy_addr),
    .bus_rdata (bus_rdata)
  );
endmodule

// File: rtl/iphy_access_port_chk.sv
module iphy_access_port_chk #(
  parameter int BUS_AW = 4,
  parameter int BUS_DW = 32,
  parameter int PHY_AW = 16,
  parameter int PHY_DW = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [BUS_DW-1:0] bus_wdata,
  input logic [BUS_DW-1:0] bus_rdata,
  input logic              phy_wr_stb,
  input logic              phy_rd_stb
);
  localparam int IW = BUS_AW - 2;

  logic data_wr, data_rd, addr_rd;
  assign data_wr = bus_wr && (bus_addr[BUS_AW-1:2] == IW'(1));
  assign data_rd = bus_rd && (bus_addr[BUS_AW-1:2] == IW'(1));
  assign addr_rd = bus_rd && (bus_addr[BUS_AW-1:2] == IW'(0));

  // R1: strobes are quiet in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!phy_wr_stb && !phy_rd_stb));

  // R4: a write strobe is always caused by a commit access one cycle earlier
  a_r4_wr_cause: assert property (@(posedge clk) disable iff (rst)
    phy_wr_stb |-> $past(data_wr && bus_wdata[PHY_DW+1]));

  // R6 and R8: a read strobe follows a read command or a combined write
  a_r6_rd_cause: assert property (@(posedge clk) disable iff (rst)
    phy_rd_stb |-> ($past(data_wr && bus_wdata[PHY_DW]) || $past(phy_wr_stb)));

  // R6: the data word reads with its upper half zero
  a_r6_data_upper_zero: assert property (@(posedge clk) disable iff (rst)
    $past(data_rd) |-> (bus_rdata[BUS_DW-1:PHY_DW] == '0));

  // R2: the address word reads with bits above the address zero
  a_r2_addr_upper_zero: assert property (@(posedge clk) disable iff (rst)
    $past(addr_rd) |-> (bus_rdata[BUS_DW-1:PHY_AW] == '0));
endmodule

bind iphy_access_port iphy_access_port_chk #(
  .BUS_AW(BUS_AW), .BUS_DW(BUS_DW), .PHY_AW(PHY_AW), .PHY_DW(PHY_DW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .phy_wr_stb (phy_wr_stb),
  .phy_rd_stb (phy_rd_stb)
);

// File: tb/iphy_access_port_test.sv
`timescale 1ns/100ps
module iphy_access_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        phy_wr_stb, phy_rd_stb;
  logic [15:0] phy_addr, phy_wdata, phy_rdata;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  iphy_access_port uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .phy_wr_stb(phy_wr_stb), .phy_rd_stb(phy_rd_stb),
    .phy_addr(phy_addr), .phy_wdata(phy_wdata), .phy_rdata(phy_rdata)
  );

  // PHY register file: write on strobe, read combinationally
  logic [15:0] phy_mem [256];
  initial for (int i = 0; i < 256; i++) phy_mem[i] = 16'(i * 3 + 1);
  always @(posedge clk) if (phy_wr_stb) phy_mem[phy_addr[7:0]] <= phy_wdata;
  assign phy_rdata = phy_mem[phy_addr[7:0]];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_arr [256];
  bit m_wr_now, m_rd_now, m_pend, m_rdv;
  int m_addr, m_stage, m_wval, m_result, m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) m_arr[i] = (i * 3 + 1) & 16'hFFFF;
      m_wr_now = 0; m_rd_now = 0; m_pend = 0; m_rdv = 0;
      m_addr = 0; m_stage = 0; m_wval = 0; m_result = 0; m_rdata = 0;
    end else begin
      bit c, w, r;
      m_rdv = bus_rd;
      if (bus_rd) begin
        case (bus_addr >> 2)
          0: m_rdata = m_addr;
          1: m_rdata = m_result;
          default: m_rdata = 0;
        endcase
      end
      if (m_rd_now) m_result = m_arr[m_addr & 255];
      if (m_wr_now) m_arr[m_addr & 255] = m_wval;
      c = 0; w = 0; r = 0;
      if (bus_wr && (bus_addr >> 2) == 0) m_addr = bus_wdata & 32'hFFFF;
      if (bus_wr && (bus_addr >> 2) == 1) begin
        c = bus_wdata[18]; w = bus_wdata[17]; r = bus_wdata[16];
      end
      if (c) m_stage = bus_wdata & 32'hFFFF;
      if (w) m_wval = m_stage;
      m_rd_now = (r && !w) || m_pend;
      m_pend = r && w;
      m_wr_now = w;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(phy_wr_stb == m_wr_now, "R4 wr strobe", 32'(phy_wr_stb), 32'(m_wr_now));
      chk(phy_rd_stb == m_rd_now, "R6 rd strobe", 32'(phy_rd_stb), 32'(m_rd_now));
      if (m_wr_now) begin
        chk(phy_wdata == m_wval[15:0], "R4 wr data", 32'(phy_wdata), m_wval);
        chk(phy_addr == m_addr[15:0], "R4 wr addr", 32'(phy_addr), m_addr);
      end
      if (m_rd_now) chk(phy_addr == m_addr[15:0], "R6 rd addr", 32'(phy_addr), m_addr);
      if (m_rdv) chk(bus_rdata == m_rdata, "R10 bus rdata", bus_rdata, m_rdata);
    end
  end

  task automatic bwrite(input logic [3:0] off, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = off; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bread(input logic [3:0] off, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = off;
    @(negedge clk); bus_rd = 1'b0;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!phy_wr_stb && !phy_rd_stb, "R1 strobes idle", 32'({phy_wr_stb, phy_rd_stb}), 0);
    bread(4'h0, 32'h0, "R1 addr word");
    bread(4'h4, 32'h0, "R1 data word");

    bwrite(4'h0, 32'hABCD_0012);
    bread(4'h0, 32'h0000_0012, "R2 addr low half only");

    bwrite(4'h4, 32'h0000_1111);            // R9: no command bits
    bwrite(4'h4, 32'h0002_2222);            // R5: commit without capture
    idle(2);
    bwrite(4'h4, 32'h0001_0000);
    idle(2);
    bread(4'h4, 32'h0, "R5 commit of reset staging");

    bwrite(4'h4, 32'h0004_5A5A);            // R3 capture
    bwrite(4'h4, 32'h0002_FFFF);            // R4 commit uses staged
    idle(2);
    bwrite(4'h4, 32'h0001_0000);
    idle(2);
    bread(4'h4, 32'h0000_5A5A, "R3 R4 staged value committed");

    bwrite(4'h4, 32'h0006_0777);            // R7 capture+commit
    idle(2);
    bwrite(4'h4, 32'h0001_0000);
    idle(2);
    bread(4'h4, 32'h0000_0777, "R7 same-access capture");

    bwrite(4'h0, 32'h0000_0034);
    bwrite(4'h4, 32'h0001_0000);
    idle(2);
    bread(4'h4, 32'h0000_009D, "R6 read of preset register");

    bwrite(4'h4, 32'h0003_0000);            // R8 write then read
    idle(3);
    bread(4'h4, 32'h0000_0777, "R8 read sees new write");

    bwrite(4'h4, 32'h0007_1234);            // all three bits
    idle(3);
    bread(4'h4, 32'h0000_1234, "R8 all command bits");

    bwrite(4'h4, 32'h0000_BEEF);            // R9 ignored
    bwrite(4'h0, 32'h0000_0035);
    bwrite(4'h4, 32'h0002_0000);
    idle(2);
    bwrite(4'h4, 32'h0001_0000);
    idle(2);
    bread(4'h4, 32'h0000_1234, "R9 plain data write ignored");

    bread(4'h8, 32'h0, "R10 unmapped offset 8");
    bread(4'hC, 32'h0, "R10 unmapped offset 12");
    bread(4'h4, 32'h0000_1234, "R10 repeated read stable");

    // back-to-back commands, checked by the model each cycle
    bwrite(4'h4, 32'h0003_0000);
    bwrite(4'h4, 32'h0001_0000);
    bwrite(4'h4, 32'h0006_4321);
    idle(3);
    bread(4'h4, 32'h0000_1234, "R8 pending read then new write");

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    bread(4'h0, 32'h0, "R1 address cleared by reset");
    bread(4'h4, 32'h0, "R1 result cleared by reset");
    idle(2);
    finish_run();
  end
endmodule